// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block serves one half-bridge leg. It takes a single PWM level and produces the digital controls for the high-side and low-side gate drivers. A high PWM level selects the high-side switch and a low level selects the low-side switch. On every change of side, the outgoing gate switches off at once. The incoming gate switches on only after a fixed dead-time during which both gates are off.

Each turn-on starts a timed shaping sequence. A boost output asks the analog stage for the strong source current during the first part of the transition, and the weak current after that. A 3-bit gate-resistance code steps from high to low resistance in equal slices and then settles at the lowest setting. A high-impedance-source mode holds the code at a fixed medium value to limit dv/dt. Each side also has a Miller clamp enable that rises a short delay after its gate turns off and drops when its gate turns on again.

A fault-override input forces both gates off. The block then stays off until the override is released and PWM has been seen low. All timing is counted in cycles of a 200 MHz clock (5 ns each). The dead-time, boost length, step length and clamp delay are module parameters in cycles, with defaults of 44, 10, 5 and 8 cycles.

Top module: `hb_gate_sequencer`

## Requirements
- R1: `hs_gate` and `ls_gate` are never both 1 in the same cycle.
- R2: Between one gate falling and the other rising, both gates stay off for DEAD_CYC cycles. The default of 44 cycles is 220 ns, which lies in the range 200 ns to under 300 ns.
- R3: PWM sampled 1 selects the high side and PWM sampled 0 selects the low side. The outgoing gate falls at the first clock edge that samples the new level. The incoming gate rises DEAD_CYC edges after that.
- R4: The boost output of a side is 1 for exactly the first BOOST_CYC cycles (default 10, 50 ns) of each on-period of that side. It is 0 at all other times.
- R5: In normal mode, `rgate_code` is 0 while both gates are off. From a gate's rise it follows the codes 4, 3, 2, 1, holding each for STEP_CYC cycles (default 5, 25 ns), and then stays at 0. The code values are 0 = 0.5 ohm, 1 = 1 ohm, 2 = 2 ohm, 3 = 4 ohm, 4 = 8 ohm and 5 = 10 ohm.
- R6: While `hiz_mode` is 1, `rgate_code` is 3 (4 ohm) in every cycle, starting one cycle after `hiz_mode` is sampled.
- R7: The clamp enable of a side rises CLAMP_CYC cycles (default 8, 40 ns) after that side's gate falls.
- R8: A side's clamp enable stays 1 until that side's gate rises, and it drops at that same edge. A side's clamp enable and gate are never both 1.
- R9: At the edge after `fault_force` is sampled 1, both gates are 0. The gates then stay off, whatever PWM does, until the override has been released and PWM has been sampled 0. After that, the low side turns on DEAD_CYC edges later.
- R10: During reset all outputs are 0. After reset both gates stay off until PWM is sampled 0.
- R11: If PWM returns to the previous side during a dead-time, the dead-time restarts toward that side. The new gate then rises DEAD_CYC edges after the reversal is sampled, and the other gate never turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Leg command: 1 selects the high side, 0 the low side |
| fault_force | input | 1 | Override that forces both gates off |
| hiz_mode | input | 1 | High-impedance-source mode: fixed 4 ohm code |
| hs_gate | output | 1 | High-side gate-on command |
| ls_gate | output | 1 | Low-side gate-on command |
| hs_boost | output | 1 | High-side strong source current select |
| ls_boost | output | 1 | Low-side strong source current select |
| rgate_code | output | 3 | Gate-resistance select code |
| hs_clamp | output | 1 | High-side Miller clamp enable |
| ls_clamp | output | 1 | Low-side Miller clamp enable |

## Verification
The assertions check the invariants on every cycle:
- the two gates are never on together;
- each rise of a gate follows at least DEAD_CYC off cycles;
- a gate and its own clamp are never both on;
- every gate rise starts with boost;
- an override always clears both gates;
- the high-impedance mode always yields code 3.

Only the bench scenarios can show the exact edges at which things happen: the gate rise after DEAD_CYC, the exact boost length, the full 4-3-2-1-0 resistance staircase, the clamp delay of CLAMP_CYC, the dead-time restart on a PWM reversal, and the requirement to see PWM low after a reset or an override.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_DEAD = 2'd1,
        PH_ON   = 2'd2
    } phase_e;

    localparam logic [2:0] RG_0P5 = 3'd0;
    localparam logic [2:0] RG_1   = 3'd1;
    localparam logic [2:0] RG_2   = 3'd2;
    localparam logic [2:0] RG_4   = 3'd3;
    localparam logic [2:0] RG_8   = 3'd4;
    localparam logic [2:0] RG_10  = 3'd5;

    // Resistance code for a given step index of the turn-on staircase.
    function automatic logic [2:0] step_code(input logic [2:0] idx);
        case (idx)
            3'd0:    step_code = RG_8;
            3'd1:    step_code = RG_4;
            3'd2:    step_code = RG_2;
            3'd3:    step_code = RG_1;
            default: step_code = RG_0P5;
        endcase
    endfunction

endpackage

// File: rtl/hb_dead_fsm.sv
module hb_dead_fsm
    import hb_seq_pkg::*;
#(
    parameter int DEAD_CYC = 44,
    parameter int CNT_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm,
    input  logic fault,
    output logic hs_d,
    output logic ls_d,
    output logic hs_q,
    output logic ls_q
);
    localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_CYC - 1);

    typedef struct packed {
        phase_e           phase;
        logic             tgt_hs;
        logic [CNT_W-1:0] tmr;
        logic             hs;
        logic             ls;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault) begin
            st_d.phase  = PH_WAIT;
            st_d.tgt_hs = 1'b0;
            st_d.tmr    = '0;
        end else begin
            case (st_q.phase)
                PH_WAIT: begin
                    if (!pwm) begin
                        st_d.phase  = PH_DEAD;
                        st_d.tgt_hs = 1'b0;
                        st_d.tmr    = '0;
                    end
                end
                PH_DEAD: begin
                    if (pwm != st_q.tgt_hs) begin
                        st_d.tgt_hs = pwm;
                        st_d.tmr    = '0;
                    end else if (st_q.tmr == DEAD_LAST) begin
                        st_d.phase = PH_ON;
                        st_d.tmr   = '0;
                    end else begin
                        st_d.tmr = st_q.tmr + 1'b1;
                    end
                end
                PH_ON: begin
                    if (pwm != st_q.tgt_hs) begin
                        st_d.phase  = PH_DEAD;
                        st_d.tgt_hs = pwm;
                        st_d.tmr    = '0;
                    end
                end
                default: begin
                    st_d.phase = PH_WAIT;
                    st_d.tmr   = '0;
                end
            endcase
        end
        st_d.hs = (st_d.phase == PH_ON) &&  st_d.tgt_hs;
        st_d.ls = (st_d.phase == PH_ON) && !st_d.tgt_hs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_d = st_d.hs;
    assign ls_d = st_d.ls;
    assign hs_q = st_q.hs;
    assign ls_q = st_q.ls;

endmodule

// File: rtl/hb_turnon_shaper.sv
module hb_turnon_shaper
    import hb_seq_pkg::*;
#(
    parameter int BOOST_CYC = 10,
    parameter int STEP_CYC  = 5,
    parameter int NUM_STEPS = 4,
    parameter int CNT_W     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_d,
    input  logic       hiz,
    output logic       boost_q,
    output logic [2:0] rcode_q
);
    localparam logic [CNT_W-1:0] BOOST_LIM = CNT_W'(BOOST_CYC);
    localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_CYC - 1);
    localparam logic [2:0]       IDX_END   = 3'(NUM_STEPS);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] tmr;
        logic [2:0]       sidx;
        logic [CNT_W-1:0] stmr;
        logic             boost;
        logic [2:0]       rcode;
    } shp_t;

    shp_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!on_d) begin
            sh_d.active = 1'b0;
            sh_d.tmr    = '0;
            sh_d.sidx   = '0;
            sh_d.stmr   = '0;
        end else if (!sh_q.active) begin
            sh_d.active = 1'b1;
            sh_d.tmr    = '0;
            sh_d.sidx   = '0;
            sh_d.stmr   = '0;
        end else begin
            if (sh_q.tmr != '1) sh_d.tmr = sh_q.tmr + 1'b1;
            if (sh_q.sidx != IDX_END) begin
                if (sh_q.stmr == STEP_LAST) begin
                    sh_d.stmr = '0;
                    sh_d.sidx = sh_q.sidx + 1'b1;
                end else begin
                    sh_d.stmr = sh_q.stmr + 1'b1;
                end
            end
        end
        sh_d.boost = on_d && (sh_d.tmr < BOOST_LIM);
        if (hiz)       sh_d.rcode = RG_4;
        else if (on_d) sh_d.rcode = step_code(sh_d.sidx);
        else           sh_d.rcode = RG_0P5;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign boost_q = sh_q.boost;
    assign rcode_q = sh_q.rcode;

endmodule

// File: rtl/hb_clamp_timer.sv
module hb_clamp_timer #(
    parameter int CLAMP_CYC = 8,
    parameter int CNT_W     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_d,
    output logic clamp_q
);
    localparam logic [CNT_W-1:0] FIRE = CNT_W'(CLAMP_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             clamp;
    } clp_t;

    clp_t cl_d, cl_q;

    always_comb begin
        cl_d = cl_q;
        if (gate_d)              cl_d.cnt = '0;
        else if (cl_q.cnt != FIRE) cl_d.cnt = cl_q.cnt + 1'b1;
        cl_d.clamp = !gate_d && (cl_d.cnt == FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cl_q <= '0;
        else        cl_q <= cl_d;
    end

    assign clamp_q = cl_q.clamp;

endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
    import hb_seq_pkg::*;
#(
    parameter int DEAD_CYC  = 44,
    parameter int BOOST_CYC = 10,
    parameter int STEP_CYC  = 5,
    parameter int CLAMP_CYC = 8,
    parameter int CNT_W     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_in,
    input  logic       fault_force,
    input  logic       hiz_mode,
    output logic       hs_gate,
    output logic       ls_gate,
    output logic       hs_boost,
    output logic       ls_boost,
    output logic [2:0] rgate_code,
    output logic       hs_clamp,
    output logic       ls_clamp
);
    localparam int NUM_SIDES = 2;   // index 0 = low side, 1 = high side
    localparam int NUM_STEPS = 4;

    logic [NUM_SIDES-1:0] gate_d;
    logic [NUM_SIDES-1:0] gate_q;
    logic [NUM_SIDES-1:0] clamp_q;
    logic                 boost_q;

    hb_dead_fsm #(
        .DEAD_CYC (DEAD_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .pwm   (pwm_in),
        .fault (fault_force),
        .hs_d  (gate_d[1]),
        .ls_d  (gate_d[0]),
        .hs_q  (gate_q[1]),
        .ls_q  (gate_q[0])
    );

    hb_turnon_shaper #(
        .BOOST_CYC (BOOST_CYC),
        .STEP_CYC  (STEP_CYC),
        .NUM_STEPS (NUM_STEPS),
        .CNT_W     (CNT_W)
    ) u_shaper (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_d    (|gate_d),
        .hiz     (hiz_mode),
        .boost_q (boost_q),
        .rcode_q (rgate_code)
    );

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_clamp
        hb_clamp_timer #(
            .CLAMP_CYC (CLAMP_CYC),
            .CNT_W     (CNT_W)
        ) u_clamp (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate_d  (gate_d[g]),
            .clamp_q (clamp_q[g])
        );
    end

    assign hs_gate  = gate_q[1];
    assign ls_gate  = gate_q[0];
    assign hs_boost = boost_q & gate_q[1];
    assign ls_boost = boost_q & gate_q[0];
    assign hs_clamp = clamp_q[1];
    assign ls_clamp = clamp_q[0];

endmodule

// File: rtl/hb_gate_sequencer_chk.sv
module hb_gate_sequencer_chk #(
    parameter int DEAD_CYC = 44,
    parameter int CNT_W    = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fault_force,
    input logic       hiz_mode,
    input logic       hs_gate,
    input logic       ls_gate,
    input logic       hs_boost,
    input logic       ls_boost,
    input logic [2:0] rgate_code,
    input logic       hs_clamp,
    input logic       ls_clamp
);
    localparam logic [CNT_W-1:0] DEAD_MIN = CNT_W'(DEAD_CYC);

    logic [CNT_W-1:0] off_run;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run <= '0;
            seen_q  <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (hs_gate || ls_gate) off_run <= '0;
            else if (off_run != '1) off_run <= off_run + 1'b1;
        end
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate)); // R1

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_gate) || $rose(ls_gate)) |-> (off_run >= DEAD_MIN)); // R2

    AST_HS_BOOST_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> hs_boost); // R4

    AST_LS_BOOST_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> ls_boost); // R4

    AST_HIZ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(hiz_mode)) |-> (rgate_code == 3'd3)); // R6

    AST_HS_CLAMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && hs_clamp)); // R8

    AST_LS_CLAMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_gate && ls_clamp)); // R8

    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault_force |=> (!hs_gate && !ls_gate)); // R9

endmodule

bind hb_gate_sequencer hb_gate_sequencer_chk #(
    .DEAD_CYC (DEAD_CYC),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_force (fault_force),
    .hiz_mode    (hiz_mode),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate),
    .hs_boost    (hs_boost),
    .ls_boost    (ls_boost),
    .rgate_code  (rgate_code),
    .hs_clamp    (hs_clamp),
    .ls_clamp    (ls_clamp)
);

// File: tb/sim_hb_gate_sequencer.sv
`timescale 1ns/1ps
module sim_hb_gate_sequencer;
    localparam real CLK_PERIOD = 5.0;
    localparam int  DEAD  = 44;
    localparam int  BOOST = 10;
    localparam int  STEP  = 5;
    localparam int  CLAMP = 8;
    localparam int  RISE_K = DEAD + 1;  // sample index of incoming gate rise

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b1;
    logic       fault_force = 1'b0;
    logic       hiz_mode = 1'b0;
    logic       hs_gate, ls_gate, hs_boost, ls_boost, hs_clamp, ls_clamp;
    logic [2:0] rgate_code;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    hb_gate_sequencer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_in      (pwm_in),
        .fault_force (fault_force),
        .hiz_mode    (hiz_mode),
        .hs_gate     (hs_gate),
        .ls_gate     (ls_gate),
        .hs_boost    (hs_boost),
        .ls_boost    (ls_boost),
        .rgate_code  (rgate_code),
        .hs_clamp    (hs_clamp),
        .ls_clamp    (ls_clamp)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(input int k, input bit hz);
        int j;
        if (hz) return 3;
        j = k - RISE_K;
        if (j < 0) return 0;
        if (j / STEP < 4) return 4 - j / STEP;
        return 0;
    endfunction

    task automatic t_reset();
        int bad;
        rst_n = 1'b0; pwm_in = 1'b1;
        repeat (4) @(negedge clk);
        check({hs_gate, ls_gate, hs_boost, ls_boost, hs_clamp, ls_clamp, rgate_code} == '0,
              "R10", "outputs in reset", {hs_gate, ls_gate, hs_clamp, ls_clamp}, 0);
        rst_n = 1'b1;
        bad = 0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (hs_gate || ls_gate) bad++;
        end
        check(bad == 0, "R10", "gates on with pwm high after reset", bad, 0);
    endtask

    task automatic t_first_low();
        int rise = -1;
        int hs_seen = 0;
        pwm_in = 1'b0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (ls_gate && rise < 0) rise = k;
            if (hs_gate) hs_seen++;
        end
        check(rise == RISE_K, "R3", "first low-side rise sample", rise, RISE_K);
        check(hs_seen == 0, "R3", "high side on during low command", hs_seen, 0);
        check((rise - 1) * 5 >= 200 && (rise - 1) * 5 < 300, "R2", "dead time ns",
              (rise - 1) * 5, 220);
    endtask

    // Full transition check; to_hs selects the incoming side.
    task automatic t_turn(input bit to_hs, input bit hz);
        int fall = -1, rise = -1, crise = -1, cfall = -1;
        int boost_n = 0, boost_bad = 0, code_bad = 0, overlap = 0, bad_code = 0;
        logic in_g, out_g, in_b, out_b, in_c, out_c;
        string rq;
        pwm_in = to_hs;
        rq = hz ? "R6" : "R5";
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            in_g  = to_hs ? hs_gate  : ls_gate;
            out_g = to_hs ? ls_gate  : hs_gate;
            in_b  = to_hs ? hs_boost : ls_boost;
            out_b = to_hs ? ls_boost : hs_boost;
            in_c  = to_hs ? hs_clamp : ls_clamp;
            out_c = to_hs ? ls_clamp : hs_clamp;
            if (!out_g && fall < 0) fall = k;
            if (in_g && rise < 0) rise = k;
            if (out_c && crise < 0) crise = k;
            if (!in_c && cfall < 0) cfall = k;
            if (hs_gate && ls_gate) overlap++;
            if (in_b) boost_n++;
            if (in_b != (k >= RISE_K && k < RISE_K + BOOST) || out_b) boost_bad++;
            if (int'(rgate_code) != exp_code(k, hz)) begin
                code_bad++;
                bad_code = rgate_code;
            end
        end
        check(fall == 1, "R3", "outgoing gate fall sample", fall, 1);
        check(rise == RISE_K, "R3", "incoming gate rise sample", rise, RISE_K);
        check(overlap == 0, "R1", "cycles with both gates on", overlap, 0);
        check(boost_n == BOOST && boost_bad == 0, "R4", "boost cycles", boost_n, BOOST);
        check(code_bad == 0, rq, "resistance code mismatches", bad_code, code_bad);
        check(crise == 1 + CLAMP, "R7", "outgoing clamp rise sample", crise, 1 + CLAMP);
        check(cfall == RISE_K, "R8", "incoming clamp drop sample", cfall, RISE_K);
    endtask

    task automatic t_reversal();
        int ls_seen = 0, rise = -1, hs_fall = -1;
        pwm_in = 1'b0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (!hs_gate && hs_fall < 0) hs_fall = k;
            if (ls_gate) ls_seen++;
        end
        pwm_in = 1'b1;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (hs_gate && rise < 0) rise = k;
            if (ls_gate) ls_seen++;
        end
        check(hs_fall == 1, "R11", "high side fall on reversal start", hs_fall, 1);
        check(rise == RISE_K, "R11", "restarted dead-time rise sample", rise, RISE_K);
        check(ls_seen == 0, "R11", "low side on during reversal", ls_seen, 0);
    endtask

    task automatic t_fault();
        int bad = 0, rise = -1;
        @(negedge clk);
        fault_force = 1'b1;
        @(negedge clk);
        check(!hs_gate && !ls_gate, "R9", "gates one edge after fault", {hs_gate, ls_gate}, 0);
        for (int k = 2; k <= 42; k++) begin
            if (k % 7 == 0) pwm_in = ~pwm_in;
            @(negedge clk);
            if (hs_gate || ls_gate) bad++;
        end
        fault_force = 1'b0;
        pwm_in = 1'b1;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (hs_gate || ls_gate) bad++;
        end
        check(bad == 0, "R9", "gate cycles while blocked", bad, 0);
        pwm_in = 1'b0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (ls_gate && rise < 0) rise = k;
        end
        check(rise == RISE_K, "R9", "low-side rise after release", rise, RISE_K);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_first_low();
        t_turn(1'b1, 1'b0);
        t_turn(1'b0, 1'b0);
        hiz_mode = 1'b1;
        repeat (3) @(negedge clk);
        check(rgate_code == 3'd3, "R6", "code with low side on in hiz", rgate_code, 3);
        t_turn(1'b1, 1'b1);
        t_turn(1'b0, 1'b1);
        hiz_mode = 1'b0;
        repeat (3) @(negedge clk);
        t_turn(1'b1, 1'b0);
        t_reversal();
        repeat (20) @(negedge clk);
        t_fault();
        finish_run();
    end

endmodule